// File: doc/BRIEF.md
# Privilege Trap Entry Sequencer

This block moves a simple processor core from user privilege into kernel privilege when an event arrives. Three event classes start the entry: a fault raised by the executing instruction, an external interrupt, and a software trap used for system calls. Each event carries a vector number. The vector selects a handler address from an internal table that software writes.

On entry the block switches from the user stack to a kernel stack when the interrupted code was not already at level 0. It then writes five context words downward on that stack through a memory write port. Once the last word is written, it presents the handler address with a kernel code selector, and the privilege level becomes 0. A return request reads the five words back from the stack and restores the interrupted selectors, pointers and flags. The privilege level then comes from the restored code selector. The core supplies the current instruction pointer. The block holds the code selector, stack selector, stack pointer and flags.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, `priv` is 3, `busy`, `mem_we` and `jump_valid` are low, `sp` equals `USER_SP`, `ss` equals `USER_SS`, and `flags` equals `USER_FLAGS`.
- R2: For an accepted event, `busy` is high for exactly 5 cycles. `jump_valid` is high for one cycle, in the cycle after `busy` falls.
- R3: On entry, `jump_ip` is the table word at the event's vector. `cs` becomes `KERNEL_CS`, whose low two bits are 00, so `priv` is 0.
- R4: Entry from a nonzero level loads `ss`/`sp` from the kernel stack configuration before writing. It then writes 32-bit words at sp-4, sp-8, sp-12, sp-16 and sp-20, in this order: old stack selector, old stack pointer, flags, old code selector, instruction pointer. After that, `sp` is the kernel sp minus 20.
- R5: Entry while `priv` is 0 skips the stack switch. The five words are written below the current `sp`, and `ss` is unchanged.
- R6: When events are pending together, a fault is served before a trap, and a trap is served before an interrupt.
- R7: An interrupt is accepted only while `flags` bit 9 (interrupt enable) is 1. Entry clears bit 9. An interrupt that arrives while bit 9 is 0 stays pending and is served once bit 9 is 1 again.
- R8: An event that arrives while `busy` is high is not lost. It is served after the current sequence.
- R9: A return request reads the five words upward from `sp` and restores `jump_ip`, `cs`, `flags`, `sp` and `ss`. `priv` then equals the low two bits of the restored `cs`.
- R10: A table write with `tbl_we` high stores `tbl_data` at `tbl_idx`. The kernel stack selector and pointer load when `kstk_ld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_fault | input | 1 | Fault event pulse |
| ev_fault_vec | input | 8 | Fault vector |
| ev_trap | input | 1 | Software trap pulse |
| ev_trap_vec | input | 8 | Trap vector |
| ev_irq | input | 1 | Interrupt pulse |
| ev_irq_vec | input | 8 | Interrupt vector |
| ret_req | input | 1 | Return request pulse |
| cur_ip | input | 32 | Core's current instruction pointer |
| kstk_ld | input | 1 | Load kernel stack configuration |
| kstk_ss | input | 16 | Kernel stack selector |
| kstk_sp | input | 32 | Kernel stack top |
| tbl_we | input | 1 | Handler table write enable |
| tbl_idx | input | 8 | Handler table index |
| tbl_data | input | 32 | Handler address to store |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe, data returned next cycle |
| mem_addr | output | 32 | Stack word address |
| mem_wdata | output | 32 | Stack write data |
| mem_rdata | input | 32 | Stack read data |
| busy | output | 1 | Sequence in progress |
| jump_valid | output | 1 | New fetch target valid |
| jump_ip | output | 32 | New instruction pointer |
| cs | output | 16 | Code selector |
| ss | output | 16 | Stack selector |
| sp | output | 32 | Stack pointer |
| flags | output | 32 | Flags word |
| priv | output | 2 | Current privilege level |

## Verification
Handler presentation and the acceptance of the next pending event can fall in the same cycle. The cycle where `jump_valid` is high is idle, so a waiting event is taken at its closing edge. The bench provokes this by raising a fault, a trap and an interrupt together, and separately by pulsing a fault while an entry is still busy. It judges the result by the second entry's handler address and by the second frame. That frame must sit right below the first one, with no stack switch, because the code selector is already at level 0. The interrupt held back by the cleared enable bit is then judged after two returns.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  typedef enum logic [1:0] {EV_FAULT, EV_TRAP, EV_IRQ, EV_RET} ev_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_POP} seq_state_e;
endpackage

// File: rtl/trap_rst_sync.sv
module trap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_seq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_req,
  input  logic [VEC_W-1:0] fault_vec,
  input  logic             trap_req,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             ret_req,
  input  logic             irq_en,
  input  logic             take,
  output logic             grant_valid,
  output ev_kind_e         grant_kind,
  output logic [VEC_W-1:0] grant_vec
);
  localparam int NUM_EV = 3;

  logic [3:0]       req_in, pend_q, pend_d, clr;
  logic [VEC_W-1:0] vec_in [NUM_EV];
  logic [VEC_W-1:0] vec_q  [NUM_EV];

  assign req_in    = {ret_req, irq_req, trap_req, fault_req};
  assign vec_in[0] = fault_vec;
  assign vec_in[1] = trap_vec;
  assign vec_in[2] = irq_vec;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_vec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         vec_q[g] <= '0;
      else if (req_in[g]) vec_q[g] <= vec_in[g];
    end
  end

  // fixed priority: fault, trap, enabled interrupt, return
  always_comb begin
    grant_valid = 1'b1;
    grant_kind  = EV_RET;
    grant_vec   = '0;
    if (pend_q[0]) begin
      grant_kind = EV_FAULT;
      grant_vec  = vec_q[0];
    end else if (pend_q[1]) begin
      grant_kind = EV_TRAP;
      grant_vec  = vec_q[1];
    end else if (pend_q[2] && irq_en) begin
      grant_kind = EV_IRQ;
      grant_vec  = vec_q[2];
    end else if (!pend_q[3]) begin
      grant_valid = 1'b0;
    end
  end

  always_comb begin
    clr    = '0;
    if (take) clr[grant_kind] = 1'b1;
    pend_d = (pend_q & ~clr) | req_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && grant_kind == EV_IRQ |-> irq_en);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[2] && !(take && grant_kind == EV_IRQ) |=> pend_q[2]);
endmodule

// File: rtl/trap_vec_table.sv
module trap_vec_table #(
  parameter int VEC_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [VEC_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [VEC_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << VEC_W;

  logic [DATA_W-1:0] tbl_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) tbl_q[widx] <= wdata;
  end

  assign rdata = tbl_q[ridx];
endmodule

// File: rtl/trap_ctx_engine.sv
module trap_ctx_engine
  import trap_seq_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              SEL_W      = 16,
  parameter int              IE_BIT     = 9,
  parameter logic [15:0]     KERNEL_CS  = 16'h0008,
  parameter logic [15:0]     USER_CS    = 16'h001B,
  parameter logic [15:0]     USER_SS    = 16'h0023,
  parameter logic [31:0]     USER_SP    = 32'h0000_0080,
  parameter logic [31:0]     USER_FLAGS = 32'h0000_0202
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_valid,
  input  ev_kind_e          grant_kind,
  input  logic [DATA_W-1:0] handler,
  input  logic [DATA_W-1:0] cur_ip,
  input  logic              kstk_ld,
  input  logic [SEL_W-1:0]  kstk_ss,
  input  logic [DATA_W-1:0] kstk_sp,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              take,
  output logic              irq_en,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              jump_valid,
  output logic [DATA_W-1:0] jump_ip,
  output logic [SEL_W-1:0]  cs,
  output logic [SEL_W-1:0]  ss,
  output logic [DATA_W-1:0] sp,
  output logic [DATA_W-1:0] flags
);
  localparam int          NWORDS  = 5;
  localparam logic [2:0]  LAST_WR = 3'(NWORDS - 1);
  localparam logic [2:0]  LAST_RD = 3'(NWORDS);
  localparam int          PAD     = DATA_W - SEL_W;
  localparam logic [DATA_W-1:0] FRAME_B = DATA_W'(NWORDS * 4);

  seq_state_e        state_q, state_d;
  logic [2:0]        cnt_q, cnt_d;
  logic [SEL_W-1:0]  cs_q, cs_d, ss_q, ss_d, kss_q;
  logic [DATA_W-1:0] sp_q, sp_d, flags_q, flags_d, ksp_q;
  logic [DATA_W-1:0] hnd_q, hnd_d, jip_q, jip_d;
  logic              jv_q, jv_d;
  logic [DATA_W-1:0] frame_q [NWORDS];
  logic [DATA_W-1:0] frame_d [NWORDS];
  logic [DATA_W-1:0] off;

  assign off       = {{(DATA_W-3){1'b0}}, cnt_q} << 2;
  assign mem_we    = (state_q == ST_PUSH);
  assign mem_re    = (state_q == ST_POP) && (cnt_q < LAST_RD);
  assign mem_addr  = mem_we ? (sp_q - off - DATA_W'(4)) : (sp_q + off);
  assign mem_wdata = frame_q[cnt_q];
  assign busy      = (state_q != ST_IDLE);
  assign irq_en    = flags_q[IE_BIT];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cs_d    = cs_q;
    ss_d    = ss_q;
    sp_d    = sp_q;
    flags_d = flags_q;
    hnd_d   = hnd_q;
    jip_d   = jip_q;
    jv_d    = 1'b0;
    frame_d = frame_q;
    take    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (grant_valid) begin
          take  = 1'b1;
          cnt_d = '0;
          if (grant_kind == EV_RET) begin
            state_d = ST_POP;
          end else begin
            state_d    = ST_PUSH;
            hnd_d      = handler;
            frame_d[0] = {{PAD{1'b0}}, ss_q};
            frame_d[1] = sp_q;
            frame_d[2] = flags_q;
            frame_d[3] = {{PAD{1'b0}}, cs_q};
            frame_d[4] = cur_ip;
            if (cs_q[1:0] != 2'b00) begin
              ss_d = kss_q;
              sp_d = ksp_q;
            end
          end
        end
      end
      ST_PUSH: begin
        cnt_d = cnt_q + 3'd1;
        if (cnt_q == LAST_WR) begin
          state_d         = ST_IDLE;
          sp_d            = sp_q - FRAME_B;
          cs_d            = KERNEL_CS[SEL_W-1:0];
          flags_d[IE_BIT] = 1'b0;
          jv_d            = 1'b1;
          jip_d           = hnd_q;
        end
      end
      ST_POP: begin
        cnt_d = cnt_q + 3'd1;
        if (cnt_q != 3'd0) frame_d[3'd5 - cnt_q] = mem_rdata;
        if (cnt_q == LAST_RD) begin
          state_d = ST_IDLE;
          ss_d    = mem_rdata[SEL_W-1:0];
          sp_d    = frame_q[1];
          flags_d = frame_q[2];
          cs_d    = frame_q[3][SEL_W-1:0];
          jip_d   = frame_q[4];
          jv_d    = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cs_q    <= USER_CS[SEL_W-1:0];
      ss_q    <= USER_SS[SEL_W-1:0];
      sp_q    <= USER_SP[DATA_W-1:0];
      flags_q <= USER_FLAGS[DATA_W-1:0];
      hnd_q   <= '0;
      jip_q   <= '0;
      jv_q    <= 1'b0;
      for (int i = 0; i < NWORDS; i++) frame_q[i] <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cs_q    <= cs_d;
      ss_q    <= ss_d;
      sp_q    <= sp_d;
      flags_q <= flags_d;
      hnd_q   <= hnd_d;
      jip_q   <= jip_d;
      jv_q    <= jv_d;
      frame_q <= frame_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kss_q <= '0;
      ksp_q <= '0;
    end else if (kstk_ld) begin
      kss_q <= kstk_ss;
      ksp_q <= kstk_sp;
    end
  end

  assign jump_valid = jv_q;
  assign jump_ip    = jip_q;
  assign cs         = cs_q;
  assign ss         = ss_q;
  assign sp         = sp_q;
  assign flags      = flags_q;

  // R4
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) - DATA_W'(4));

  // R3
  entry_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jv_q && $past(mem_we) |-> cs_q[1:0] == 2'b00 && !flags_q[IE_BIT]);

  // R2
  write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> busy && !jv_q);
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int          VEC_W      = 8,
  parameter int          DATA_W     = 32,
  parameter int          SEL_W      = 16,
  parameter int          IE_BIT     = 9,
  parameter logic [15:0] KERNEL_CS  = 16'h0008,
  parameter logic [15:0] USER_CS    = 16'h001B,
  parameter logic [15:0] USER_SS    = 16'h0023,
  parameter logic [31:0] USER_SP    = 32'h0000_0080,
  parameter logic [31:0] USER_FLAGS = 32'h0000_0202
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_fault,
  input  logic [VEC_W-1:0]  ev_fault_vec,
  input  logic              ev_trap,
  input  logic [VEC_W-1:0]  ev_trap_vec,
  input  logic              ev_irq,
  input  logic [VEC_W-1:0]  ev_irq_vec,
  input  logic              ret_req,
  input  logic [DATA_W-1:0] cur_ip,
  input  logic              kstk_ld,
  input  logic [SEL_W-1:0]  kstk_ss,
  input  logic [DATA_W-1:0] kstk_sp,
  input  logic              tbl_we,
  input  logic [VEC_W-1:0]  tbl_idx,
  input  logic [DATA_W-1:0] tbl_data,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              jump_valid,
  output logic [DATA_W-1:0] jump_ip,
  output logic [SEL_W-1:0]  cs,
  output logic [SEL_W-1:0]  ss,
  output logic [DATA_W-1:0] sp,
  output logic [DATA_W-1:0] flags,
  output logic [1:0]        priv
);
  logic              rst_n_s;
  logic              grant_valid, take, irq_en;
  ev_kind_e          grant_kind;
  logic [VEC_W-1:0]  grant_vec;
  logic [DATA_W-1:0] handler;

  trap_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  trap_arbiter #(.VEC_W(VEC_W)) u_arb (
    .clk(clk), .rst_n(rst_n_s),
    .fault_req(ev_fault), .fault_vec(ev_fault_vec),
    .trap_req(ev_trap), .trap_vec(ev_trap_vec),
    .irq_req(ev_irq), .irq_vec(ev_irq_vec),
    .ret_req(ret_req), .irq_en(irq_en), .take(take),
    .grant_valid(grant_valid), .grant_kind(grant_kind), .grant_vec(grant_vec)
  );

  trap_vec_table #(.VEC_W(VEC_W), .DATA_W(DATA_W)) u_tbl (
    .clk(clk), .we(tbl_we), .widx(tbl_idx), .wdata(tbl_data),
    .ridx(grant_vec), .rdata(handler)
  );

  trap_ctx_engine #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .IE_BIT(IE_BIT), .KERNEL_CS(KERNEL_CS),
    .USER_CS(USER_CS), .USER_SS(USER_SS), .USER_SP(USER_SP), .USER_FLAGS(USER_FLAGS)
  ) u_eng (
    .clk(clk), .rst_n(rst_n_s),
    .grant_valid(grant_valid), .grant_kind(grant_kind), .handler(handler),
    .cur_ip(cur_ip), .kstk_ld(kstk_ld), .kstk_ss(kstk_ss), .kstk_sp(kstk_sp),
    .mem_rdata(mem_rdata), .take(take), .irq_en(irq_en),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .jump_valid(jump_valid), .jump_ip(jump_ip),
    .cs(cs), .ss(ss), .sp(sp), .flags(flags)
  );

  assign priv = cs[1:0];
endmodule

// File: tb/trap_entry_seq_bench.sv
module trap_entry_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] U_CS = 16'h001B, U_SS = 16'h0023, K_CS = 16'h0008, K_SS = 16'h0010;
  localparam logic [31:0] U_SP = 32'h80, U_FL = 32'h202, K_SP = 32'hC0;
  // kind(8) vec(8) ip(32); kind 0 fault, 1 trap, 2 irq
  localparam logic [47:0] ROWS [4] = '{
    {8'd0, 8'h0E, 32'h400}, {8'd1, 8'h80, 32'h404},
    {8'd2, 8'h21, 32'h408}, {8'd1, 8'hFF, 32'h40C}};

  logic clk = 0, rst_n = 0;
  logic ev_fault = 0, ev_trap = 0, ev_irq = 0, ret_req = 0, kstk_ld = 0, tbl_we = 0;
  logic [7:0] ev_fault_vec = 0, ev_trap_vec = 0, ev_irq_vec = 0, tbl_idx = 0;
  logic [31:0] cur_ip = 0, kstk_sp = 0, tbl_data = 0, mem_rdata = 0;
  logic [15:0] kstk_ss = 0;
  logic mem_we, mem_re, busy, jump_valid;
  logic [31:0] mem_addr, mem_wdata, jump_ip, sp, flags;
  logic [15:0] cs, ss;
  logic [1:0] priv;
  logic [31:0] smem [64];
  int checks = 0, errors = 0, bcnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) smem[mem_addr[7:2]] <= mem_wdata;
    if (mem_re) mem_rdata <= smem[mem_addr[7:2]];
  end

  trap_entry_seq u_trap_entry_seq (.*);

  function automatic logic [31:0] hnd(input logic [7:0] v);
    return 32'h1000 + {20'd0, v, 4'd0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fire(input int kind, input logic [7:0] v);
    @(negedge clk);
    case (kind)
      0: begin ev_fault = 1; ev_fault_vec = v; end
      1: begin ev_trap = 1;  ev_trap_vec = v;  end
      2: begin ev_irq = 1;   ev_irq_vec = v;   end
      default: ret_req = 1;
    endcase
    @(negedge clk);
    ev_fault = 0; ev_trap = 0; ev_irq = 0; ret_req = 0;
  endtask

  task automatic wait_jump();
    bcnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (busy) bcnt++;
      if (jump_valid) return;
    end
    chk(0, "R2 jump timeout", 0, 1);
  endtask

  function automatic logic [31:0] mw(input logic [31:0] a);
    return smem[a[7:2]];
  endfunction

  task automatic chk_frame(input string req, input logic [31:0] top, input logic [31:0] s0,
                           input logic [31:0] s1, input logic [31:0] s2, input logic [31:0] s3,
                           input logic [31:0] s4);
    chk(mw(top-4)  == s0, {req, " saved ss"},    mw(top-4),  s0);
    chk(mw(top-8)  == s1, {req, " saved sp"},    mw(top-8),  s1);
    chk(mw(top-12) == s2, {req, " saved flags"}, mw(top-12), s2);
    chk(mw(top-16) == s3, {req, " saved cs"},    mw(top-16), s3);
    chk(mw(top-20) == s4, {req, " saved ip"},    mw(top-20), s4);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(priv == 2'd3, "R1 priv", 32'(priv), 3);
    chk(!busy && !mem_we && !jump_valid, "R1 idle outputs", {busy, mem_we, jump_valid}, 0);
    chk(sp == U_SP && ss == U_SS && flags == U_FL, "R1 context", sp, U_SP);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R10 configuration writes
    for (int v = 0; v < 256; v++) begin
      tbl_we = 1; tbl_idx = 8'(v); tbl_data = hnd(8'(v));
      @(negedge clk);
    end
    tbl_we = 0; kstk_ld = 1; kstk_ss = K_SS; kstk_sp = K_SP;
    @(negedge clk);
    kstk_ld = 0;

    // vector table walk: entry from user then return
    for (int r = 0; r < 4; r++) begin
      cur_ip = ROWS[r][31:0];
      fire(int'(ROWS[r][47:40]), ROWS[r][39:32]);
      wait_jump();
      chk(bcnt == 5, "R2 busy length", bcnt, 5);
      chk(jump_ip == hnd(ROWS[r][39:32]), "R3 R10 handler", jump_ip, hnd(ROWS[r][39:32]));
      chk(cs == K_CS && priv == 0, "R3 kernel cs", {16'd0, cs}, {16'd0, K_CS});
      chk(ss == K_SS && sp == K_SP - 20, "R4 kernel stack", sp, K_SP - 20);
      chk(flags[9] == 0, "R7 ie cleared", flags, U_FL & ~32'h200);
      chk_frame("R4", K_SP, {16'd0, U_SS}, U_SP, U_FL, {16'd0, U_CS}, ROWS[r][31:0]);
      fire(3, 0);
      wait_jump();
      chk(bcnt == 6, "R9 return busy", bcnt, 6);
      chk(jump_ip == ROWS[r][31:0], "R9 ip", jump_ip, ROWS[r][31:0]);
      chk(priv == 3 && cs == U_CS, "R9 priv", {16'd0, cs}, {16'd0, U_CS});
      chk(sp == U_SP && ss == U_SS && flags == U_FL, "R9 restore", sp, U_SP);
    end

    // R6 simultaneous events; R5 nested entry at level 0; R7 irq held
    cur_ip = 32'h500;
    @(negedge clk);
    ev_fault = 1; ev_fault_vec = 8'h0D; ev_trap = 1; ev_trap_vec = 8'h30;
    ev_irq = 1; ev_irq_vec = 8'h40;
    @(negedge clk);
    ev_fault = 0; ev_trap = 0; ev_irq = 0;
    wait_jump();
    chk(jump_ip == hnd(8'h0D), "R6 fault first", jump_ip, hnd(8'h0D));
    wait_jump();
    chk(jump_ip == hnd(8'h30), "R6 trap second", jump_ip, hnd(8'h30));
    chk(ss == K_SS && sp == K_SP - 40, "R5 no stack switch", sp, K_SP - 40);
    chk_frame("R5", K_SP - 20, {16'd0, K_SS}, K_SP - 20, 32'h002, {16'd0, K_CS}, 32'h500);
    begin
      int seen = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (busy || jump_valid) seen++;
      end
      chk(seen == 0, "R7 irq blocked", seen, 0);
    end
    fire(3, 0);
    wait_jump();
    chk(jump_ip == 32'h500 && priv == 0, "R9 nested return", jump_ip, 32'h500);
    chk(sp == K_SP - 20 && flags == 32'h002, "R9 nested restore", sp, K_SP - 20);
    cur_ip = 32'h600;
    fire(3, 0);
    wait_jump();
    chk(jump_ip == 32'h500 && priv == 3, "R9 user return", jump_ip, 32'h500);
    wait_jump();
    chk(jump_ip == hnd(8'h40), "R7 irq served later", jump_ip, hnd(8'h40));
    chk(mw(K_SP - 20) == 32'h600, "R7 irq frame ip", mw(K_SP - 20), 32'h600);
    fire(3, 0);
    wait_jump();

    // R8 event arriving while busy
    cur_ip = 32'h700;
    fire(1, 8'h05);
    @(negedge clk);
    chk(busy == 1, "R8 busy seen", 32'(busy), 1);
    ev_fault = 1; ev_fault_vec = 8'h07;
    @(negedge clk);
    ev_fault = 0;
    wait_jump();
    chk(jump_ip == hnd(8'h05), "R8 first", jump_ip, hnd(8'h05));
    wait_jump();
    chk(jump_ip == hnd(8'h07), "R8 held event", jump_ip, hnd(8'h07));
    fire(3, 0);
    wait_jump();
    fire(3, 0);
    wait_jump();
    chk(priv == 3 && sp == U_SP, "R9 final", sp, U_SP);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule